// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from the main clock. It divides in two cascaded stages. A coarse stage divides by a power of two, chosen by a small exponent field. A fine stage then divides the coarse ticks by a programmable count. The resulting serial clock toggles once every half period. Each toggle comes with a one-cycle strobe that tells a shift engine whether the clock just left its idle level (leading edge) or returned to it (trailing edge).

Software chooses the exponent and count for a target rate; that choice is outside this block. The block clamps any count below the legal floor, so the serial clock can never run faster than the fastest legal rate. It samples the exponent, the count and the idle polarity only while it is stopped. Changing these inputs while a word is being shifted therefore has no effect. While stopped, the clock rests at its idle level and both divider counters are held cleared.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: After reset, sclk, lead_stb and trail_stb are 0. The stored setting is exponent 0, count 4 and polarity 0. If run is high from the first cycle after reset, the first leading strobe comes after 10 main cycles and sclk goes high.
- R2: While running with stored exponent D and count B (B of 4 or more), every half period lasts (B+1)·2^(D+1) main cycles. The first strobe appears that many cycles after the first clock edge at which run is high.
- R3: The exponent values 0, 1, 2 and 3 make the coarse stage divide by 2, 4, 8 and 16 respectively.
- R4: A count value from 0 to 3 acts exactly like a count of 4.
- R5: With polarity 1, sclk idles high. With polarity 0, it idles low. The new level appears one clock edge after the value is presented while stopped.
- R6: lead_stb is high for one cycle, in the cycle in which sclk first shows its non-idle level. trail_stb is high for one cycle, in the cycle in which sclk first shows its idle level again. The two strobes alternate, starting with lead_stb.
- R7: When run is low at a clock edge, sclk returns to idle after that edge and both strobes stay low. A later start produces a full first half period.
- R8: Changes to the exponent, count or polarity inputs while run is high do not change the running half period or the idle level. They take effect only after run has been low for at least one edge.
- R9: The full serial period ranges from 20 main cycles (exponent 0, count 4) to 2048 main cycles (exponent 3, count 63).
- R10: lead_stb and trail_stb are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to generate the serial clock; low holds idle and reloads the setting |
| cpol | input | 1 | Idle level of sclk (1 = idle high) |
| div_sel | input | DIV_W | Exponent of the power-of-two coarse stage |
| brg_sel | input | BRG_W | Fine-stage count; half period is count+1 coarse ticks |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on the edge leaving idle |
| trail_stb | output | 1 | One-cycle strobe on the edge returning to idle |

## Verification
The bound checker watches several properties on every cycle: the two strobes are mutually exclusive, every running sclk change is paired with a strobe and every strobe with a change, the block is quiet at the idle level after a stopped edge, and each half period lies between the clamped minimum and the largest legal length. Only the bench scenarios can show the exact half-period length for each exponent and count, the reset default, the clamp of small counts, and that inputs changed mid-word are ignored until the next stop. The bench sweeps every count for the two lowest exponents and picks counts at the corners for the two highest.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

   // phase of the serial clock relative to its idle level
   typedef enum logic {
      PH_REST  = 1'b0,
      PH_SWING = 1'b1
   } sclk_phase_e;

   // main-clock cycles in one serial half period for a given setting
   function automatic int half_cycles(input int dexp, input int cnt, input int cnt_min);
      int eff;
      eff = (cnt < cnt_min) ? cnt_min : cnt;
      return (eff + 1) * (2 << dexp);
   endfunction

endpackage

// File: rtl/presc_cfg_shadow.sv
module presc_cfg_shadow #(
   parameter int DIV_W    = 2,
   parameter int BRG_W    = 6,
   parameter int BRG_MIN  = 4,
   parameter int RST_DIV  = 0,
   parameter int RST_BRG  = 4,
   parameter bit RST_CPOL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] div_in,
   input  logic [BRG_W-1:0] brg_in,
   input  logic             cpol_in,
   output logic [DIV_W-1:0] div_q,
   output logic [BRG_W-1:0] brg_q,
   output logic             cpol_q
);
   localparam logic [BRG_W-1:0] FLOOR = BRG_W'(BRG_MIN);

   logic [BRG_W-1:0] brg_eff;

   generate
      if (BRG_MIN > 0) begin : g_clamp
         assign brg_eff = (brg_in < FLOOR) ? FLOOR : brg_in;
      end else begin : g_pass
         assign brg_eff = brg_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= DIV_W'(RST_DIV);
         brg_q  <= BRG_W'(RST_BRG);
         cpol_q <= RST_CPOL;
      end else if (load) begin
         div_q  <= div_in;
         brg_q  <= brg_eff;
         cpol_q <= cpol_in;
      end
   end
endmodule

// File: rtl/presc_pow2_stage.sv
module presc_pow2_stage #(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] dexp,
   output logic             tick
);
   // widest ratio is 2^(2^DIV_W), so the counter needs 2^DIV_W bits
   localparam int CNT_W = 2 ** DIV_W;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   span;
   logic [CNT_W-1:0] mask;

   always_comb begin
      span = ((CNT_W + 1)'(2) << dexp) - (CNT_W + 1)'(1);
      mask = span[CNT_W-1:0];
   end

   // tick when all bits covered by the selected ratio are ones
   assign tick = run && ((cnt & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else                cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/presc_brg_stage.sv
module presc_brg_stage #(
   parameter int BRG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [BRG_W-1:0] limit,
   output logic             half
);
   logic [BRG_W-1:0] cnt;
   logic             at_top;

   assign at_top = (cnt == limit);
   assign half   = run && tick && at_top;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (tick)      cnt <= at_top ? '0 : cnt + BRG_W'(1);
   end
endmodule

// File: rtl/presc_edge_gen.sv
module presc_edge_gen
   import spi_presc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic half,
   input  logic cpol,
   output logic sclk,
   output logic lead_stb,
   output logic trail_stb
);
   sclk_phase_e ph;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph        <= PH_REST;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else if (!run) begin
         ph        <= PH_REST;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else begin
         lead_stb  <= half && (ph == PH_REST);
         trail_stb <= half && (ph == PH_SWING);
         if (half) ph <= (ph == PH_REST) ? PH_SWING : PH_REST;
      end
   end

   assign sclk = cpol ^ (ph == PH_SWING);
endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler #(
   parameter int DIV_W    = 2,
   parameter int BRG_W    = 6,
   parameter int BRG_MIN  = 4,
   parameter int RST_DIV  = 0,
   parameter int RST_BRG  = 4,
   parameter bit RST_CPOL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             cpol,
   input  logic [DIV_W-1:0] div_sel,
   input  logic [BRG_W-1:0] brg_sel,
   output logic             sclk,
   output logic             lead_stb,
   output logic             trail_stb
);
   generate
      if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
         $error("DIV_W must be 1..3");
      end
      if (BRG_MIN >= (2 ** BRG_W)) begin : g_bad_min
         $error("BRG_MIN must fit in BRG_W bits");
      end
      if (RST_BRG < BRG_MIN || RST_BRG >= (2 ** BRG_W)) begin : g_bad_rst
         $error("RST_BRG outside legal window");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [BRG_W-1:0] brg_q;
   logic             cpol_q;
   logic             tick;
   logic             half;

   presc_cfg_shadow #(
      .DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_MIN(BRG_MIN),
      .RST_DIV(RST_DIV), .RST_BRG(RST_BRG), .RST_CPOL(RST_CPOL)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(!run),
      .div_in(div_sel), .brg_in(brg_sel), .cpol_in(cpol),
      .div_q(div_q), .brg_q(brg_q), .cpol_q(cpol_q)
   );

   presc_pow2_stage #(.DIV_W(DIV_W)) u_coarse (
      .clk(clk), .rst_n(rst_n), .run(run), .dexp(div_q), .tick(tick)
   );

   presc_brg_stage #(.BRG_W(BRG_W)) u_fine (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
      .limit(brg_q), .half(half)
   );

   presc_edge_gen u_edge (
      .clk(clk), .rst_n(rst_n), .run(run), .half(half), .cpol(cpol_q),
      .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
   );
endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk
   import spi_presc_pkg::*;
#(
   parameter int DIV_W   = 2,
   parameter int BRG_W   = 6,
   parameter int BRG_MIN = 4
) (
   input logic clk,
   input logic rst_n,
   input logic run,
   input logic cpol,
   input logic sclk,
   input logic lead_stb,
   input logic trail_stb
);
   localparam int MIN_HALF = half_cycles(0, BRG_MIN, BRG_MIN);
   localparam int MAX_HALF = half_cycles((2 ** DIV_W) - 1, (2 ** BRG_W) - 1, BRG_MIN);
   localparam int GAP_W    = $clog2(MAX_HALF + 2) + 1;

   logic [GAP_W-1:0] gap;

   always_ff @(posedge clk) begin
      if (!rst_n || !run || lead_stb || trail_stb) gap <= GAP_W'(1);
      else if (gap != '1)                          gap <= gap + GAP_W'(1);
   end

   // R10
   strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_stb && trail_stb));

   // R6
   edge_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(run) && (sclk != $past(sclk))) |-> (lead_stb || trail_stb));

   // R6
   strobe_moves_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (lead_stb || trail_stb)) |-> (sclk != $past(sclk)));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(run)) |-> (!lead_stb && !trail_stb && sclk == $past(cpol)));

   // R4
   half_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_stb || trail_stb) |-> (int'(gap) >= MIN_HALF));

   // R9
   half_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (int'(gap) <= MAX_HALF + 1));
endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk #(
   .DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_MIN(BRG_MIN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol),
   .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
);

// File: tb/spi_sclk_prescaler_tb.sv
module spi_sclk_prescaler_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       cpol = 1'b0;
   logic [1:0] div_sel = '0;
   logic [5:0] brg_sel = '0;
   logic       sclk, lead_stb, trail_stb;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   spi_sclk_prescaler u_dut (
      .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol),
      .div_sel(div_sel), .brg_sel(brg_sel),
      .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
   );

   function automatic int exp_half(input int d, input int b);
      int e;
      e = (b < 4) ? 4 : b;
      return (e + 1) * (2 << d);
   endfunction

   task automatic chk(input string req, input int got, input int expv);
      n_tests++;
      if (got !== expv) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, expv);
      end
   endtask

   // counts negedges until the wanted strobe is seen
   task automatic wait_strobe(input bit want_lead, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!(want_lead ? lead_stb : trail_stb) && n < 5000);
   endtask

   task automatic run_cfg(input int d, input int b, input bit pol, input string req);
      int h, n;
      h = exp_half(d, b);
      @(negedge clk);
      run = 1'b0; div_sel = 2'(d); brg_sel = 6'(b); cpol = pol;
      @(negedge clk);
      @(negedge clk);
      chk({req, " R5 idle level"}, int'(sclk), int'(pol));
      run = 1'b1;
      wait_strobe(1'b1, n);
      chk({req, " lead gap"}, n, h);
      chk({req, " R6 level after lead"}, int'(sclk), int'(!pol));
      @(negedge clk);
      chk("R6 lead single cycle", int'(lead_stb), 0);
      wait_strobe(1'b0, n);
      chk({req, " trail gap"}, n + 1, h);
      chk({req, " R6 level after trail"}, int'(sclk), int'(pol));
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000 && !done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got %0d expected %0d", cycles, 190000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin
      int n;
      // R1: reset defaults, run already high when reset lifts
      run = 1'b1; div_sel = 2'd3; brg_sel = 6'd63; cpol = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 sclk in reset", int'(sclk), 0);
      chk("R1 strobes in reset", int'(lead_stb | trail_stb), 0);
      rst_n = 1'b1;
      wait_strobe(1'b1, n);
      chk("R1 default half period", n, 10);
      chk("R1 default polarity", int'(sclk), 1);

      // R2 R3 R4 R5: full count sweep for the two lowest exponents
      for (int d = 0; d < 2; d++) begin
         for (int b = 0; b < 64; b++) begin
            run_cfg(d, b, b[0], (b < 4) ? "R4" : "R2/R3");
         end
      end
      // R3: corner counts for the two highest exponents
      for (int d = 2; d < 4; d++) begin
         run_cfg(d, 0, 1'b0, "R4/R3");
         run_cfg(d, 4, 1'b1, "R3");
         run_cfg(d, 17, 1'b0, "R3");
         run_cfg(d, 40, 1'b1, "R3");
      end
      // R9: the two rate limits
      run_cfg(0, 4, 1'b0, "R9 fastest");
      run_cfg(3, 63, 1'b1, "R9 slowest");

      // R7: stop in mid half period, then restart
      run_cfg(1, 5, 1'b0, "R7 pre");
      repeat (5) @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      chk("R7 idle after stop", int'(sclk), 0);
      chk("R7 strobes after stop", int'(lead_stb | trail_stb), 0);
      run = 1'b1;
      wait_strobe(1'b1, n);
      chk("R7 full half period on restart", n, 24);

      // R8: changes while running are ignored
      run_cfg(0, 4, 1'b0, "R8 pre");
      div_sel = 2'd3; brg_sel = 6'd63; cpol = 1'b1;
      wait_strobe(1'b1, n);
      chk("R8 period kept after change", n, 10);
      chk("R8 polarity kept after change", int'(sclk), 1);
      wait_strobe(1'b0, n);
      chk("R8 period kept on trail", n, 10);
      chk("R8 idle level kept", int'(sclk), 0);
      run = 1'b0;
      @(negedge clk);
      chk("R8 new polarity after stop", int'(sclk), 1);
      @(negedge clk);
      run = 1'b1;
      wait_strobe(1'b1, n);
      chk("R8 new setting after stop", n, 1024);
      run = 1'b0;

      // R10: strobes checked here at the ports too
      chk("R10 strobes exclusive", int'(lead_stb & trail_stb), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule